// File: doc/BRIEF.md
# Arithmetic Unit with Programmable Range Flag

This block is a 16-bit arithmetic slice whose single status flag watches results for a condition that an instruction selects. The flag supports block-floating-point scaling: software picks a condition, then runs arithmetic, and the flag reports when a result has overflowed, has come close to overflowing, or is zero. Four control opcodes choose the condition. The choice is kept in a small mode register and stays in force until another control opcode replaces it. While a control opcode runs, the data output is zero.

Four constant opcodes put fixed words on the output. An add and a subtract supply results for the flag to judge. Every opcode is registered once, so the result and its flag appear together on the clock edge after the opcode is presented.

Top module: `range_flag_alu`

## Requirements
- R1: After reset the result and the flag are 0 and the flag mode is overflow. With that mode in force, 0x4000 + 0x0000 gives a flag of 0.
- R2: Opcode 0x00 yields A+B and opcode 0x01 yields A−B, both modulo 2^16. The result appears on the clock edge after the opcode is presented.
- R3: In overflow mode (selected by 0x18) the flag is 1 exactly when the two's complement add or subtract overflows, that is, when the carry into bit 15 differs from the carry out of it.
- R4: In near-by-two mode (selected by 0x19) the flag is 1 when the add or subtract overflows, or when result bits 15 and 14 differ.
- R5: In near-by-four mode (selected by 0x1A) the flag is 1 when the add or subtract overflows, or when result bits 15, 14 and 13 are not all equal.
- R6: In zero mode (selected by 0x1B) the flag is 1 exactly when the result is 0x0000. This includes the cycle of the 0x1B instruction itself.
- R7: Opcodes 0x18 to 0x1B output 0x0000 whatever the operands are. Their flag is then judged on that zero word under the newly selected mode, so it is 1 only for 0x1B.
- R8: Opcode 0x1C outputs 0x0001, 0x1D outputs 0x00FF, 0x1E outputs 0x000F and 0x1F outputs 0x5555.
- R9: The mode changes only on opcodes 0x18 to 0x1B. Every other result, including the constants, is judged under the mode in force, with no overflow term. For example, 0x5555 raises the flag in near-by-two mode and does not raise it in overflow mode.
- R10: Opcodes 0x02 to 0x17 output 0x0000 and leave the mode unchanged.
- R11: The flag is registered in the same stage as the result, so the flag always describes the result shown alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opCode | input | 5 | Instruction |
| result | output | 16 | Registered result word |
| rangeFlag | output | 1 | Registered range flag for that result |

## Verification
The embedded properties assume that opcode and operands are stable and known at every rising edge once reset has been released. Several of them also compare a result with the operands through $past, so they assume the inputs of the previous cycle are the ones that produced the current output. The bench changes inputs only on falling edges and presents exactly one instruction per cycle. It keeps reset high for several whole cycles before the first instruction, so no property ever sees an unknown operand or a partial cycle.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_ADD   = 5'h00;
  localparam logic [OPC_W-1:0] OPC_SUB   = 5'h01;
  localparam logic [2:0]       OPC_MODE_HI  = 3'b110;  // 0x18..0x1B
  localparam logic [2:0]       OPC_CONST_HI = 3'b111;  // 0x1C..0x1F

  typedef enum logic [1:0] {
    MODE_OVF   = 2'd0,
    MODE_NEAR2 = 2'd1,
    MODE_NEAR4 = 2'd2,
    MODE_ZERO  = 2'd3
  } flagMode_e;

  typedef enum logic [1:0] {
    CONST_ONE  = 2'd0,
    CONST_BYTE = 2'd1,
    CONST_NIB  = 2'd2,
    CONST_ALT  = 2'd3
  } constSel_e;

  typedef struct packed {
    logic      doArith;
    logic      doSub;
    logic      selConst;
    constSel_e constSel;
    logic      loadMode;
    flagMode_e evalMode;
  } aluStrobes_t;
endpackage

// File: rtl/rfalu_ctrl.sv
module rfalu_ctrl
  import rfalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opCode,
  output aluStrobes_t      strb
);
  flagMode_e modeQ;
  flagMode_e opMode;
  logic      isMode;

  assign isMode = (opCode[4:2] == OPC_MODE_HI);
  assign opMode = flagMode_e'(opCode[1:0]);

  always_comb begin
    strb          = '0;
    strb.doArith  = (opCode == OPC_ADD) || (opCode == OPC_SUB);
    strb.doSub    = (opCode == OPC_SUB);
    strb.selConst = (opCode[4:2] == OPC_CONST_HI);
    strb.constSel = constSel_e'(opCode[1:0]);
    strb.loadMode = isMode;
    strb.evalMode = isMode ? opMode : modeQ;
  end

  always_ff @(posedge clk) begin
    if (rst)         modeQ <= MODE_OVF;
    else if (isMode) modeQ <= opMode;
  end

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !isMode |=> $stable(modeQ));

  // R1
  mode_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> modeQ == MODE_OVF);
endmodule

// File: rtl/rfalu_datapath.sv
module rfalu_datapath
  import rfalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strb,
  output logic [WIDTH-1:0] resultQ,
  output logic             flagQ
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] K_ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] K_BYTE = WIDTH'(8'hFF);
  localparam logic [WIDTH-1:0] K_NIB  = WIDTH'(4'hF);

  logic [WIDTH-1:0] altWord;
  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   sumFull;
  logic [MSB:0]     lowSum;
  logic             carryIn, carryOut, ovf;
  logic [WIDTH-1:0] nextResult;
  logic             nextFlag;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_alt
      assign altWord[i] = (i % 2 == 0);
    end
  endgenerate

  assign bEff     = strb.doSub ? ~opB : opB;
  assign sumFull  = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, strb.doSub};
  assign lowSum   = {1'b0, opA[MSB-1:0]} + {1'b0, bEff[MSB-1:0]} + {{MSB{1'b0}}, strb.doSub};
  assign carryIn  = lowSum[MSB];
  assign carryOut = sumFull[WIDTH];
  assign ovf      = strb.doArith & (carryIn ^ carryOut);

  always_comb begin
    if (strb.doArith) nextResult = sumFull[WIDTH-1:0];
    else if (strb.selConst) begin
      unique case (strb.constSel)
        CONST_ONE:  nextResult = K_ONE;
        CONST_BYTE: nextResult = K_BYTE;
        CONST_NIB:  nextResult = K_NIB;
        default:    nextResult = altWord;
      endcase
    end else nextResult = '0;
  end

  always_comb begin
    unique case (strb.evalMode)
      MODE_OVF:   nextFlag = ovf;
      MODE_NEAR2: nextFlag = ovf | (nextResult[MSB] ^ nextResult[MSB-1]);
      MODE_NEAR4: nextFlag = ovf | (nextResult[MSB] ^ nextResult[MSB-1])
                                 | (nextResult[MSB-1] ^ nextResult[MSB-2]);
      default:    nextFlag = (nextResult == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      flagQ   <= 1'b0;
    end else begin
      resultQ <= nextResult;
      flagQ   <= nextFlag;
    end
  end

  // R7
  ctrl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadMode |=> resultQ == '0);

  // R6
  zero_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.loadMode && strb.evalMode == MODE_ZERO) |=> flagQ);

  // R2
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.doArith && !strb.doSub) |=> resultQ == $past(opA) + $past(opB));

  // R3
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.doArith && !strb.doSub && strb.evalMode == MODE_OVF && opA[MSB] == opB[MSB])
      |=> flagQ == (resultQ[MSB] != $past(opA[MSB])));

  // R8
  const_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    strb.selConst |=> resultQ != '0);
endmodule

// File: rtl/range_flag_alu.sv
module range_flag_alu
  import rfalu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [4:0]  opCode,
  output logic [15:0] result,
  output logic        rangeFlag
);
  aluStrobes_t strb;

  rfalu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opCode (opCode),
    .strb   (strb)
  );

  rfalu_datapath #(.WIDTH(16)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .opA     (opA),
    .opB     (opB),
    .strb    (strb),
    .resultQ (result),
    .flagQ   (rangeFlag)
  );
endmodule

// File: tb/range_flag_alu_tb.sv
module range_flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [4:0]  opCode = 5'h02;
  logic [15:0] result;
  logic        rangeFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int tbMode = 0;

  logic [15:0] qRes[$];
  logic        qFlag[$];
  string       qReq[$];

  always #5 clk = ~clk;

  range_flag_alu u_dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .rangeFlag(rangeFlag)
  );

  function automatic logic judge(int mode, logic [15:0] r, logic ov);
    case (mode)
      0: return ov;
      1: return ov | (r[15] != r[14]);
      2: return ov | !((r[15:13] == 3'b000) || (r[15:13] == 3'b111));
      default: return r == 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] gotR, logic gotF,
                       logic [15:0] expR, logic expF);
    checks++;
    if (gotR !== expR || gotF !== expF) begin
      fails++;
      $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
               req, gotR, gotF, expR, expF);
    end
  endtask

  // driver: present one instruction, push the expected outcome
  task automatic issue(string req, logic [4:0] op, logic [15:0] a, logic [15:0] b);
    logic [15:0] r;
    logic ov;
    int m;
    @(negedge clk);
    opCode = op; opA = a; opB = b;
    ov = 1'b0;
    m = tbMode;
    if (op == 5'h00) begin
      r = a + b;
      ov = (a[15] == b[15]) && (r[15] != a[15]);
    end else if (op == 5'h01) begin
      r = a - b;
      ov = (a[15] != b[15]) && (r[15] != a[15]);
    end else if (op >= 5'h18 && op <= 5'h1B) begin
      r = 16'h0000;
      m = int'(op[1:0]);
      tbMode = m;
    end else if (op == 5'h1C) r = 16'h0001;
    else if (op == 5'h1D) r = 16'h00FF;
    else if (op == 5'h1E) r = 16'h000F;
    else if (op == 5'h1F) r = 16'h5555;
    else r = 16'h0000;
    qRes.push_back(r);
    qFlag.push_back(judge(m, r, ov));
    qReq.push_back(req);
  endtask

  // monitor: outcome registered at the edge after the instruction
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qRes.size() > 0)
        check(qReq.pop_front(), result, rangeFlag, qRes.pop_front(), qFlag.pop_front());
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: result=%h flag=%b expected completion", result, rangeFlag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check("R1", result, rangeFlag, 16'h0000, 1'b0);
    issue("R1", 5'h00, 16'h4000, 16'h0000);
    // R2 / R3: overflow mode
    issue("R2", 5'h00, 16'h1234, 16'h1111);
    issue("R2", 5'h01, 16'h0005, 16'h0007);
    issue("R3", 5'h00, 16'h7FFF, 16'h0001);
    issue("R3", 5'h01, 16'h8000, 16'h0001);
    issue("R3", 5'h00, 16'hFFFF, 16'h0001);
    issue("R3", 5'h00, 16'h8000, 16'h8000);
    issue("R9", 5'h1F, 16'h0000, 16'h0000);
    // R4: near-by-two
    issue("R7", 5'h19, 16'hFFFF, 16'hFFFF);
    issue("R4", 5'h00, 16'h3000, 16'h1000);
    issue("R4", 5'h00, 16'h1000, 16'h1000);
    issue("R4", 5'h00, 16'hE000, 16'hE000);
    issue("R4", 5'h00, 16'hE000, 16'hD000);
    issue("R4", 5'h00, 16'h7000, 16'h7000);
    issue("R9", 5'h1F, 16'h0000, 16'h0000);
    issue("R10", 5'h05, 16'h1234, 16'h4321);
    issue("R10", 5'h00, 16'h3000, 16'h1000);
    // R5: near-by-four
    issue("R7", 5'h1A, 16'h8000, 16'h0001);
    issue("R5", 5'h00, 16'h1000, 16'h1000);
    issue("R5", 5'h00, 16'h0800, 16'h0800);
    issue("R5", 5'h01, 16'h0000, 16'h1000);
    issue("R5", 5'h01, 16'h0000, 16'h2001);
    // R6: zero mode
    issue("R6", 5'h1B, 16'hAAAA, 16'h5555);
    issue("R6", 5'h01, 16'h0005, 16'h0005);
    issue("R6", 5'h01, 16'h0005, 16'h0004);
    issue("R10", 5'h17, 16'hFFFF, 16'h0001);
    // R8: constants
    issue("R8", 5'h1C, 16'h0000, 16'h0000);
    issue("R8", 5'h1D, 16'h0000, 16'h0000);
    issue("R8", 5'h1E, 16'h0000, 16'h0000);
    issue("R8", 5'h1F, 16'h0000, 16'h0000);
    // R11: back to overflow mode, flag tracks each result
    issue("R7", 5'h18, 16'h1111, 16'h2222);
    issue("R11", 5'h00, 16'h7FFF, 16'h7FFF);
    issue("R11", 5'h00, 16'h0001, 16'h0001);
    issue("R10", 5'h02, 16'h0000, 16'h0000);
    @(negedge clk);
    opCode = 5'h02;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule